// File: doc/BRIEF.md
# Two-Stage Optical Selector Gate Controller

This block drives the fast optical gates of one output select unit in a broadcast-and-select switch. The 64 possible sources are organised as 8 fiber space groups carrying 8 wavelengths each. A source is chosen in two steps. One of eight group gates opens the correct fiber, and one of eight wavelength gates then picks the channel inside it. So 16 gate enables cover all 64 channels.

Time is divided into fixed packet slots of `SLOT_CYC` clock cycles. Each slot opens with a dead-time window in which the gates may switch (`DEAD_CYC` cycles). A receiver synchronisation window follows (`SYNC_CYC` cycles), and the data window takes the rest of the slot. The `phase` output tells the receiver which window is current.

The scheduler presents a source index and a valid flag. The block samples them in the last cycle of each slot, which it marks with `slot_last`. It holds each selection in an alignment line for `ALIGN_SLOTS` slots, so the gates open when the granted packet actually reaches them. The block requires `DEAD_CYC >= 1`, `SYNC_CYC >= 1` and `SLOT_CYC - DEAD_CYC - SYNC_CYC >= 2`.

Top module: `sel_gate_ctrl`

The timing sequencer has three named states: `PH_DEAD` (code 0), `PH_SYNC` (code 1) and `PH_DATA` (code 2). It has three transitions:
- DEAD→SYNC after `DEAD_CYC` cycles.
- SYNC→DATA after `SYNC_CYC` cycles.
- DATA→DEAD after `SLOT_CYC-DEAD_CYC-SYNC_CYC` cycles. This transition is the slot boundary.

Reset enters `PH_DEAD`.

## Requirements
- R1: `fiber_en` is the one-hot decode of source index bits [5:3]: bit k is set for group k.
- R2: `lambda_en` is the one-hot decode of source index bits [2:0]: bit k is set for wavelength k.
- R3: A slot whose sampled `sched_valid` was 0 drives both `fiber_en` and `lambda_en` to all zeros for that whole slot.
- R4: Every slot lasts `SLOT_CYC` cycles, and `phase` runs through three windows in order. It reads 0 (dead) for `DEAD_CYC` cycles, then 1 (sync) for `SYNC_CYC` cycles, then 2 (data) until the slot ends. It then returns to 0.
- R5: `slot_last` is 1 exactly in the final cycle of each slot. `sched_valid` and `sched_src` are sampled only in that cycle.
- R6: A selection sampled at the end of slot n drives the gates throughout slot n+`ALIGN_SLOTS`.
- R7: The gate enables change only on entry to the dead window and stay constant for the rest of the slot. Input activity in cycles where `slot_last` is 0 has no effect on them.
- R8: During and after reset, `phase` is 0, `slot_last` is 0 and both enable buses are zero. The enables stay zero for the first `ALIGN_SLOTS` slots.
- R9: Each enable bus has at most one bit set, and either both buses are zero or both are nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sched_valid | input | 1 | A packet is scheduled for this output |
| sched_src | input | GROUP_BITS+LANE_BITS | Scheduled source index: group in the upper bits, wavelength in the lower bits |
| fiber_en | output | 2**GROUP_BITS | One-hot fiber group gate enables |
| lambda_en | output | 2**LANE_BITS | One-hot wavelength gate enables |
| phase | output | 2 | Slot window: 0 dead, 1 sync, 2 data |
| slot_last | output | 1 | Final cycle of the slot; inputs are sampled here |

## Verification
Several properties are checked on every cycle:
- The legal window order and the exact length of each window, measured with a run-length counter.
- The one-hot shape and pairing of the two gate buses.
- That the gates move only on entry to the dead window.
- That `slot_last` is followed by the dead window.

Other behaviour can only be shown by the bench's scenarios, which track the expected values slot by slot:
- That each sampled index decodes into the correct group and wavelength.
- That an idle slot clears both buses.
- That a selection appears exactly `ALIGN_SLOTS` slots after it was sampled.
- That input activity outside the sampling cycle is ignored.

// File: rtl/sgc_pkg.sv
package sgc_pkg;

    typedef enum logic [1:0] {
        PH_DEAD = 2'd0,
        PH_SYNC = 2'd1,
        PH_DATA = 2'd2
    } phase_e;

endpackage

// File: rtl/sgc_slot_timer.sv
module sgc_slot_timer
    import sgc_pkg::*;
#(
    parameter int SLOT_CYC = 64,
    parameter int DEAD_CYC = 4,
    parameter int SYNC_CYC = 8
) (
    input  logic   clk,
    input  logic   rst_n,
    output phase_e phase,
    output logic   slot_last
);
    localparam int DATA_CYC = SLOT_CYC - DEAD_CYC - SYNC_CYC;
    localparam int CW       = $clog2(SLOT_CYC);

    phase_e        state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          win_end;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PH_DEAD;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        win_end = 1'b0;
        unique case (state_q)
            PH_DEAD: begin
                win_end = (cnt_q == CW'(DEAD_CYC - 1));
                if (win_end) state_d = PH_SYNC;
            end
            PH_SYNC: begin
                win_end = (cnt_q == CW'(SYNC_CYC - 1));
                if (win_end) state_d = PH_DATA;
            end
            PH_DATA: begin
                win_end = (cnt_q == CW'(DATA_CYC - 1));
                if (win_end) state_d = PH_DEAD;
            end
            default: begin
                win_end = 1'b1;
                state_d = PH_DEAD;
            end
        endcase
        cnt_d = win_end ? '0 : cnt_q + 1'b1;
    end

    // Outputs
    always_comb begin
        phase     = state_q;
        slot_last = 1'b0;
        unique case (state_q)
            PH_DATA: slot_last = (cnt_q == CW'(DATA_CYC - 1));
            default: slot_last = 1'b0;
        endcase
    end
endmodule

// File: rtl/sgc_align_pipe.sv
module sgc_align_pipe #(
    parameter int DEPTH = 2,
    parameter int W     = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         advance,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [DEPTH];

    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_stage
            if (g == 0) begin : g_head
                always_ff @(posedge clk) begin
                    if (!rst_n)       stage[0] <= '0;
                    else if (advance) stage[0] <= d;
                end
            end else begin : g_body
                always_ff @(posedge clk) begin
                    if (!rst_n)       stage[g] <= '0;
                    else if (advance) stage[g] <= stage[g-1];
                end
            end
        end
    endgenerate

    assign q = stage[DEPTH-1];
endmodule

// File: rtl/sgc_gate_decoder.sv
module sgc_gate_decoder #(
    parameter int IDX_W = 3
) (
    input  logic                  en,
    input  logic [IDX_W-1:0]      idx,
    output logic [(1<<IDX_W)-1:0] gate
);
    localparam int N = 1 << IDX_W;

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_gate
            assign gate[g] = en && (idx == IDX_W'(g));
        end
    endgenerate
endmodule

// File: rtl/sel_gate_ctrl.sv
module sel_gate_ctrl
    import sgc_pkg::*;
#(
    parameter int GROUP_BITS  = 3,
    parameter int LANE_BITS   = 3,
    parameter int SLOT_CYC    = 64,
    parameter int DEAD_CYC    = 4,
    parameter int SYNC_CYC    = 8,
    parameter int ALIGN_SLOTS = 2
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            sched_valid,
    input  logic [GROUP_BITS+LANE_BITS-1:0] sched_src,
    output logic [(1<<GROUP_BITS)-1:0]      fiber_en,
    output logic [(1<<LANE_BITS)-1:0]       lambda_en,
    output logic [1:0]                      phase,
    output logic                            slot_last
);
    localparam int SRC_W = GROUP_BITS + LANE_BITS;
    localparam int SEL_W = SRC_W + 1;

    phase_e           ph;
    logic             last;
    logic [SEL_W-1:0] sel_q;

    sgc_slot_timer #(
        .SLOT_CYC (SLOT_CYC),
        .DEAD_CYC (DEAD_CYC),
        .SYNC_CYC (SYNC_CYC)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase     (ph),
        .slot_last (last)
    );

    // Selection advances only at the slot boundary
    sgc_align_pipe #(
        .DEPTH (ALIGN_SLOTS),
        .W     (SEL_W)
    ) u_align (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (last),
        .d       ({sched_valid, sched_src}),
        .q       (sel_q)
    );

    sgc_gate_decoder #(.IDX_W(GROUP_BITS)) u_fiber_dec (
        .en   (sel_q[SRC_W]),
        .idx  (sel_q[SRC_W-1:LANE_BITS]),
        .gate (fiber_en)
    );

    sgc_gate_decoder #(.IDX_W(LANE_BITS)) u_lambda_dec (
        .en   (sel_q[SRC_W]),
        .idx  (sel_q[LANE_BITS-1:0]),
        .gate (lambda_en)
    );

    assign phase     = ph;
    assign slot_last = last;
endmodule

// File: rtl/sel_gate_chk.sv
module sel_gate_chk
    import sgc_pkg::*;
#(
    parameter int GROUP_BITS  = 3,
    parameter int LANE_BITS   = 3,
    parameter int SLOT_CYC    = 64,
    parameter int DEAD_CYC    = 4,
    parameter int SYNC_CYC    = 8,
    parameter int ALIGN_SLOTS = 2
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            sched_valid,
    input logic [GROUP_BITS+LANE_BITS-1:0] sched_src,
    input logic [(1<<GROUP_BITS)-1:0]      fiber_en,
    input logic [(1<<LANE_BITS)-1:0]       lambda_en,
    input logic [1:0]                      phase,
    input logic                            slot_last
);
    localparam int DATA_CYC = SLOT_CYC - DEAD_CYC - SYNC_CYC;
    localparam int LW       = $clog2(SLOT_CYC + 1);

    logic [1:0]    r_ph;
    logic [LW-1:0] r_len;

    // Length of the run of the previous phase value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_ph  <= 2'(PH_DEAD);
            r_len <= '0;
        end else begin
            r_ph  <= phase;
            r_len <= (phase == r_ph) ? r_len + 1'b1 : LW'(1);
        end
    end

    // R4: legal window order
    a_r4_phase_order: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != $past(phase)) |->
            (($past(phase) == 2'(PH_DEAD) && phase == 2'(PH_SYNC)) ||
             ($past(phase) == 2'(PH_SYNC) && phase == 2'(PH_DATA)) ||
             ($past(phase) == 2'(PH_DATA) && phase == 2'(PH_DEAD))));

    // R4: window lengths
    a_r4_dead_len: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != r_ph && r_ph == 2'(PH_DEAD)) |-> (r_len == LW'(DEAD_CYC)));
    a_r4_sync_len: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != r_ph && r_ph == 2'(PH_SYNC)) |-> (r_len == LW'(SYNC_CYC)));
    a_r4_data_len: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != r_ph && r_ph == 2'(PH_DATA)) |-> (r_len == LW'(DATA_CYC)));

    // R5: the last cycle lies in the data window and is followed by dead time
    a_r5_last_in_data: assert property (@(posedge clk) disable iff (!rst_n)
        slot_last |-> (phase == 2'(PH_DATA)));
    a_r5_last_then_dead: assert property (@(posedge clk) disable iff (!rst_n)
        slot_last |=> (phase == 2'(PH_DEAD)));

    // R7: gates move only on entry to dead time
    a_r7_gates_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(fiber_en) || !$stable(lambda_en)) |->
            (phase == 2'(PH_DEAD) && $past(slot_last)));

    // R9: one-hot and paired buses
    a_r9_fiber_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fiber_en));
    a_r9_lambda_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lambda_en));
    a_r9_paired: assert property (@(posedge clk) disable iff (!rst_n)
        ((fiber_en != '0) == (lambda_en != '0)));
endmodule

bind sel_gate_ctrl sel_gate_chk #(
    .GROUP_BITS  (GROUP_BITS),
    .LANE_BITS   (LANE_BITS),
    .SLOT_CYC    (SLOT_CYC),
    .DEAD_CYC    (DEAD_CYC),
    .SYNC_CYC    (SYNC_CYC),
    .ALIGN_SLOTS (ALIGN_SLOTS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sched_valid (sched_valid),
    .sched_src   (sched_src),
    .fiber_en    (fiber_en),
    .lambda_en   (lambda_en),
    .phase       (phase),
    .slot_last   (slot_last)
);

// File: tb/sel_gate_ctrl_tb.sv
module sel_gate_ctrl_tb;
    localparam int SLOT  = 64;
    localparam int DEAD  = 4;
    localparam int SYNC  = 8;
    localparam int ALIGN = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sched_valid = 1'b0;
    logic [5:0] sched_src = '0;
    logic [7:0] fiber_en, lambda_en;
    logic [1:0] phase;
    logic       slot_last;

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;

    int         pos = 0;
    logic [6:0] mp [ALIGN];

    always #10 clk = ~clk;

    sel_gate_ctrl #(
        .GROUP_BITS(3), .LANE_BITS(3), .SLOT_CYC(SLOT),
        .DEAD_CYC(DEAD), .SYNC_CYC(SYNC), .ALIGN_SLOTS(ALIGN)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .sched_valid(sched_valid),
        .sched_src(sched_src), .fiber_en(fiber_en), .lambda_en(lambda_en),
        .phase(phase), .slot_last(slot_last)
    );

    function automatic logic [7:0] oh(input logic v, input logic [2:0] i);
        return v ? (8'd1 << i) : 8'd0;
    endfunction

    function automatic logic [1:0] exp_phase(input int p);
        if (p < DEAD)        return 2'd0;
        if (p < DEAD + SYNC) return 2'd1;
        return 2'd2;
    endfunction

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        vectors++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s at slot position %0d: got %h expected %h", req, pos, got, exp);
        end
    endtask

    // one clock: check at the current negedge, drive, advance the model
    task automatic step(input logic v, input logic [5:0] s);
        logic [6:0] cur;
        cur = mp[ALIGN-1];
        chk("R4 phase", {6'd0, phase}, {6'd0, exp_phase(pos)});
        chk("R5 slot_last", {7'd0, slot_last}, {7'd0, pos == SLOT - 1});
        if (!cur[6]) begin
            chk("R3 fiber idle", fiber_en, 8'd0);
            chk("R3 lambda idle", lambda_en, 8'd0);
        end else begin
            chk("R1 R6 R7 fiber", fiber_en, oh(1'b1, cur[5:3]));
            chk("R2 R6 R7 lambda", lambda_en, oh(1'b1, cur[2:0]));
        end
        if (pos == SLOT - 1) begin
            sched_valid = v;
            sched_src   = s;
            for (int k = ALIGN - 1; k > 0; k--) mp[k] = mp[k-1];
            mp[0] = {v, s};
        end else begin
            // activity outside the sampling cycle must be ignored (R7)
            sched_valid = 1'($urandom);
            sched_src   = 6'($urandom);
        end
        pos = (pos + 1) % SLOT;
        @(negedge clk);
    endtask

    task automatic run_slot(input logic v, input logic [5:0] s);
        for (int c = 0; c < SLOT; c++) step(v, s);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    endtask

    initial begin
        void'($urandom(32'd4177));
        for (int k = 0; k < ALIGN; k++) mp[k] = '0;
        sched_valid = 1'b1;
        sched_src   = 6'd63;
        repeat (3) @(negedge clk);
        // R8: reset state
        chk("R8 reset phase", {6'd0, phase}, 8'd0);
        chk("R8 reset slot_last", {7'd0, slot_last}, 8'd0);
        chk("R8 reset fiber", fiber_en, 8'd0);
        chk("R8 reset lambda", lambda_en, 8'd0);
        rst_n = 1'b1;
        // directed corners: extremes, group edges, idle, repeats
        run_slot(1'b1, 6'd0);
        run_slot(1'b1, 6'd63);
        run_slot(1'b0, 6'd63);
        run_slot(1'b1, 6'd7);
        run_slot(1'b1, 6'd56);
        run_slot(1'b1, 6'd21);
        run_slot(1'b1, 6'd21);
        run_slot(1'b0, 6'd0);
        run_slot(1'b1, 6'd36);
        // constrained random
        for (int n = 0; n < 250; n++)
            run_slot(($urandom % 4) != 0, 6'($urandom));
        // flush
        for (int n = 0; n <= ALIGN; n++) run_slot(1'b0, 6'd0);
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, got hang expected completion");
            summary();
            $finish;
        end
    end
endmodule